// File: doc/BRIEF.md
# Streaming Sobel Edge-Strength Engine

This block takes a camera-style pixel stream, one signed pixel per accepted transfer in raster order, and returns one edge-strength value for every pixel it accepts. Two line memories keep the two rows above the incoming pixel. A 3x3 register window slides across them. Two gradient kernels, one for horizontal change and one for vertical change, are applied to the window in the same cycle. The result is the sum of the two gradient magnitudes, with no square root.

Each result is reported at the stream position of the window's bottom-right pixel, so the output stream holds exactly as many samples as the input stream. Output position (r, c) carries the strength of the window centred on input pixel (r-1, c-1). Positions whose window would reach above row 0 or left of column 0 return zero and are still flagged valid. Both stream edges use valid/ready. A transfer takes place on a rising clock edge where valid and ready are both high. While the output is offered and not taken, it holds its data and the input is not ready. Gaps on the input side drop no data.

A start-of-frame flag sent with a pixel makes that pixel row 0, column 0, even when the previous frame was not finished. Without the flag, the position wraps by itself after the last pixel of the frame.

Top module: `sobel_edge_stream`

## Requirements
- R1: During reset and on the first cycle after it, out_valid is low and in_ready is high.
- R2: When in_ready stays high, the result for a pixel accepted at edge t is presented with out_valid high after edge t+2. The latency is three register stages.
- R3: Let w[i][j] be the window, with row i = 0 the oldest row and column j = 0 the oldest column. The horizontal gradient is (w[0][2] + 2w[1][2] + w[2][2]) - (w[0][0] + 2w[1][0] + w[2][0]). The vertical gradient is (w[2][0] + 2w[2][1] + w[2][2]) - (w[0][0] + 2w[0][1] + w[0][2]). Pixels are 9-bit two's complement.
- R4: Each gradient is clamped to the signed 11-bit range [-1024, 1023].
- R5: The output is |gx| + |gy| after clamping, as an unsigned 11-bit value that saturates at 2047.
- R6: The output at stream position (row, col) is zero when row < 2 or col < 2, and it is still delivered as a valid sample.
- R7: Each accepted pixel produces exactly one output, in order. A frame of COLS x ROWS pixels gives exactly COLS x ROWS outputs.
- R8: A pixel accepted with in_sof high is placed at row 0, column 0 whatever the current position. The following outputs match a fresh frame.
- R9: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid and out_data stay unchanged.
- R10: Idle cycles and stalls on either side change no output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Engine can take a pixel this cycle |
| in_sof | input | 1 | Offered pixel is the first of a frame |
| in_pix | input | PIX_W (9) | Signed pixel value |
| out_valid | output | 1 | Edge-strength value offered |
| out_ready | input | 1 | Downstream takes the offered value |
| out_data | output | OUT_W (11) | Unsigned edge strength |

## Verification
The hardest case to reach from the ports is saturation of both gradients in the same window, since random pixels seldom line up that way. A directed frame repeats a pattern every third row and column: one full row and one full column at the positive limit, all other pixels at the negative limit. Many windows then clamp both gradients and push the sum past 2047. A second hard case is a start-of-frame that arrives in the middle of a row. The stimulus stops a frame after a few rows and opens the next one with the flag set, while random back-pressure stalls the pipeline.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
  // kernel edge length; window is KSIZE x KSIZE
  localparam int KSIZE = 3;

  // sideband that travels with every pipeline stage
  typedef struct packed {
    logic valid;
    logic border;
  } stage_tag_t;
endpackage

// File: rtl/sobel_window.sv
module sobel_window
  import sobel_pkg::*;
#(
  parameter int COLS  = 200,
  parameter int ROWS  = 100,
  parameter int PIX_W = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic in_valid,
  input  logic in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic [KSIZE-1:0][KSIZE-1:0][PIX_W-1:0] win,
  output stage_tag_t tag
);
  localparam int CW  = $clog2(COLS);
  localparam int RW  = $clog2(ROWS);
  localparam int NLB = KSIZE - 1;

  logic          take;
  logic [CW-1:0] col_q, cur_col;
  logic [RW-1:0] row_q, cur_row;
  logic [NLB:0][PIX_W-1:0] taps;

  assign take    = en && in_valid;
  assign cur_col = in_sof ? '0 : col_q;
  assign cur_row = in_sof ? '0 : row_q;
  assign taps[0] = in_pix;

  // chain of row memories: each one delays its input by one full row
  for (genvar g = 0; g < NLB; g++) begin : g_line
    logic [PIX_W-1:0] mem [COLS];
    always_ff @(posedge clk) begin
      if (take) mem[cur_col] <= taps[g];
    end
    assign taps[g+1] = mem[cur_col];
  end

  // sliding window: column KSIZE-1 is the newest, row 0 the oldest
  always_ff @(posedge clk) begin
    if (take) begin
      for (int r = 0; r < KSIZE; r++) begin
        for (int c = 0; c < KSIZE - 1; c++) win[r][c] <= win[r][c+1];
        win[r][KSIZE-1] <= taps[KSIZE-1-r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= '0;
      row_q      <= '0;
      tag.valid  <= 1'b0;
      tag.border <= 1'b0;
    end else if (en) begin
      tag.valid <= in_valid;
      if (in_valid) begin
        tag.border <= (cur_row < RW'(NLB)) || (cur_col < CW'(NLB));
        if (cur_col == CW'(COLS - 1)) begin
          col_q <= '0;
          row_q <= (cur_row == RW'(ROWS - 1)) ? '0 : cur_row + 1'b1;
        end else begin
          col_q <= cur_col + 1'b1;
          row_q <= cur_row;
        end
      end
    end
  end
endmodule

// File: rtl/sobel_grad.sv
module sobel_grad
  import sobel_pkg::*;
#(
  parameter int PIX_W  = 9,
  parameter int GRAD_W = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic [KSIZE-1:0][KSIZE-1:0][PIX_W-1:0] win,
  input  stage_tag_t tag_in,
  output logic signed [GRAD_W-1:0] gx,
  output logic signed [GRAD_W-1:0] gy,
  output stage_tag_t tag_out
);
  localparam int RAW_W = PIX_W + 3;
  localparam int SW    = (RAW_W > GRAD_W ? RAW_W : GRAD_W) + 1;
  localparam logic signed [SW-1:0] GMAX = SW'((2 ** (GRAD_W - 1)) - 1);
  localparam logic signed [SW-1:0] GMIN = -SW'(2 ** (GRAD_W - 1));

  logic signed [SW-1:0] p [KSIZE][KSIZE];
  logic signed [SW-1:0] hx, hy;

  always_comb begin
    for (int r = 0; r < KSIZE; r++)
      for (int c = 0; c < KSIZE; c++)
        p[r][c] = {{(SW - PIX_W){win[r][c][PIX_W-1]}}, win[r][c]};
    // right column minus left column, centre row weighted by two
    hx = (p[0][2] + (p[1][2] <<< 1) + p[2][2]) - (p[0][0] + (p[1][0] <<< 1) + p[2][0]);
    // bottom row minus top row, centre column weighted by two
    hy = (p[2][0] + (p[2][1] <<< 1) + p[2][2]) - (p[0][0] + (p[0][1] <<< 1) + p[0][2]);
  end

  function automatic logic signed [GRAD_W-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > GMAX)      return GRAD_W'(GMAX);
    else if (v < GMIN) return GRAD_W'(GMIN);
    else               return GRAD_W'(v);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      gx      <= '0;
      gy      <= '0;
      tag_out <= '0;
    end else if (en) begin
      gx      <= clamp(hx);
      gy      <= clamp(hy);
      tag_out <= tag_in;
    end
  end
endmodule

// File: rtl/sobel_mag.sv
module sobel_mag
  import sobel_pkg::*;
#(
  parameter int GRAD_W = 11,
  parameter int OUT_W  = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic signed [GRAD_W-1:0] gx,
  input  logic signed [GRAD_W-1:0] gy,
  input  stage_tag_t tag_in,
  output logic [OUT_W-1:0] mag,
  output stage_tag_t tag_out
);
  localparam int AW   = GRAD_W + 1;
  localparam int SUMW = (AW > OUT_W ? AW : OUT_W) + 1;
  localparam logic [SUMW-1:0] OMAX = SUMW'((2 ** OUT_W) - 1);

  logic signed [AW-1:0] ex, ey, ax, ay;
  logic [SUMW-1:0] sum;

  always_comb begin
    ex  = {gx[GRAD_W-1], gx};
    ey  = {gy[GRAD_W-1], gy};
    ax  = (ex < 0) ? -ex : ex;
    ay  = (ey < 0) ? -ey : ey;
    sum = SUMW'(unsigned'(ax)) + SUMW'(unsigned'(ay));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag     <= '0;
      tag_out <= '0;
    end else if (en) begin
      tag_out <= tag_in;
      if (tag_in.border)   mag <= '0;
      else if (sum > OMAX) mag <= OUT_W'(OMAX);
      else                 mag <= OUT_W'(sum);
    end
  end
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
  import sobel_pkg::*;
#(
  parameter int COLS   = 200,
  parameter int ROWS   = 100,
  parameter int PIX_W  = 9,
  parameter int GRAD_W = 11,
  parameter int OUT_W  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  logic advance;
  logic [KSIZE-1:0][KSIZE-1:0][PIX_W-1:0] win;
  stage_tag_t tag_w, tag_g, tag_m;
  logic signed [GRAD_W-1:0] gx, gy;

  // single pipeline enable: every stage moves unless the last one is blocked
  assign advance   = !out_valid || out_ready;
  assign in_ready  = advance;
  assign out_valid = tag_m.valid;

  sobel_window #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_window (
    .clk(clk), .rst(rst), .en(advance),
    .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .win(win), .tag(tag_w)
  );

  sobel_grad #(.PIX_W(PIX_W), .GRAD_W(GRAD_W)) u_grad (
    .clk(clk), .rst(rst), .en(advance),
    .win(win), .tag_in(tag_w),
    .gx(gx), .gy(gy), .tag_out(tag_g)
  );

  sobel_mag #(.GRAD_W(GRAD_W), .OUT_W(OUT_W)) u_mag (
    .clk(clk), .rst(rst), .en(advance),
    .gx(gx), .gy(gy), .tag_in(tag_g),
    .mag(out_data), .tag_out(tag_m)
  );
endmodule

// File: rtl/sobel_edge_stream_chk.sv
module sobel_edge_stream_chk #(
  parameter int OUT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  logic [2:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != 3'd0));

  // R7
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= 3'd3);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  ready_pass_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);
endmodule

bind sobel_edge_stream sobel_edge_stream_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sobel_edge_stream_tb.sv
module sobel_edge_stream_tb;
  localparam int COLS = 200;
  localparam int ROWS = 100;
  localparam int NPIX = COLS * ROWS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic [8:0] in_pix = '0;
  logic in_ready, out_valid;
  logic [10:0] out_data;

  int checks = 0, errors = 0;
  int cyc = 0, sent = 0, outs = 0;
  int mode = 0, npix = 0, vpct = 100, rpct = 100;
  int cur_pix = 0;
  bit took_prev = 0, stall_prev = 0, finished = 0;
  logic [10:0] held = '0;
  int img [3][COLS];
  int exp_q[$];
  int cyc_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sobel_edge_stream u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int gen_pix(input int m, input int r, input int c);
    if (m == 0) return int'($urandom_range(0, 511)) - 256;
    if (m == 1) return int'($urandom_range(0, 15)) - 8;
    return (r % 3 == 0 || c % 3 == 0) ? 255 : -256;
  endfunction

  function automatic int px(input int r, input int c);
    return img[r % 3][c];
  endfunction

  function automatic int clamp_g(input int v);
    if (v > 1023) return 1023;
    if (v < -1024) return -1024;
    return v;
  endfunction

  // expected strength for stream position (r,c); window rows r-2..r, cols c-2..c
  task automatic model(input int r, input int c, output int val, output string tag);
    int hx, hy, cx, cy, s;
    if (r < 2 || c < 2) begin
      val = 0; tag = "R6"; return;
    end
    hx = (px(r-2, c) + 2 * px(r-1, c) + px(r, c)) - (px(r-2, c-2) + 2 * px(r-1, c-2) + px(r, c-2));
    hy = (px(r, c-2) + 2 * px(r, c-1) + px(r, c)) - (px(r-2, c-2) + 2 * px(r-2, c-1) + px(r-2, c));
    cx = clamp_g(hx);
    cy = clamp_g(hy);
    s = (cx < 0 ? -cx : cx) + (cy < 0 ? -cy : cy);
    if (s > 2047) begin val = 2047; tag = "R5"; end
    else if (cx != hx || cy != hy) begin val = s; tag = "R4"; end
    else begin val = s; tag = "R3"; end
  endtask

  task automatic step();
    int r, c, e, ec;
    string t;
    @(negedge clk);
    cyc++;
    if (stall_prev) check(out_valid && out_data == held, "R9 hold", int'(out_data), int'(held));
    out_ready = ($urandom_range(0, 99) < rpct);
    if (!(in_valid && !took_prev)) begin
      if (sent < npix && $urandom_range(0, 99) < vpct) begin
        cur_pix  = gen_pix(mode, sent / COLS, sent % COLS);
        in_valid = 1'b1;
        in_sof   = (sent == 0);
        in_pix   = 9'(cur_pix);
      end else begin
        in_valid = 1'b0;
        in_sof   = 1'b0;
      end
    end
    #1;
    check(in_ready == (!out_valid || out_ready), "R9 ready", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R7 extra output", int'(out_data), -1);
      else begin
        e = exp_q.pop_front(); ec = cyc_q.pop_front(); t = tag_q.pop_front();
        check(int'(out_data) == e, t, int'(out_data), e);
        if (vpct == 100 && rpct == 100) check(cyc - ec == 3, "R2 latency", cyc - ec, 3);
      end
      outs++;
    end
    took_prev = in_valid && in_ready;
    if (took_prev) begin
      r = sent / COLS; c = sent % COLS;
      img[r % 3][c] = cur_pix;
      model(r, c, e, t);
      exp_q.push_back(e); cyc_q.push_back(cyc); tag_q.push_back(t);
      sent++;
    end
    stall_prev = out_valid && !out_ready;
    held = out_data;
  endtask

  task automatic run_stream(input int m, input int n, input int vp, input int rp, input string req);
    mode = m; npix = n; vpct = vp; rpct = rp; sent = 0; outs = 0;
    while (sent < npix || exp_q.size() != 0) step();
    check(outs == npix, req, outs, npix);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    void'($urandom(32'h5EB0_1D77));
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R1 in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(in_ready, "R1 in_ready", int'(in_ready), 1);
    run_stream(0, NPIX, 100, 100, "R7 frame count");
    run_stream(0, NPIX, 70, 60, "R10 gapped count");
    run_stream(1, 450, 90, 80, "R7 partial count");
    run_stream(2, NPIX, 80, 90, "R8 restart count");
    run_stream(1, NPIX, 60, 100, "R10 gapped count");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule